// File: doc/BRIEF.md
# Private Cache Forwarded-Request Handler

This block sits at the head of the forwarded-request queue of a private cache controller in a MOESI directory coherence system. Each cycle it may accept one request message. It sorts the message into an event. The sort looks at the request type and at whether this cache issued the request itself, which means both the requestor ID and the requestor kind match its own. The event is then applied to the current state of the addressed line, which may be stable or transient.

One cycle after a message is accepted, the registered outputs give the outcome. The block may send a data response taken from the cache array or from the writeback buffer, and such a response can be marked exclusive. It also gives the line's next state and says whether the message is consumed (pop) or handed back to the queue for a later retry (recycle).

A DMA read has its own event. It is answered like a shared read, except that it never downgrades or invalidates the line. A DMA write is handled the same way as an exclusive request. The surrounding controller owns the cache array, the writeback buffer, the network and the processor side. It writes the next state back to the line and, after a recycle, presents the message again on a later cycle.

Top module: `fwd_handler`

## Requirements
- R1: Type codes: 0 exclusive read, 1 shared read, 2 DMA read, 3 DMA write, 4 invalidate, 5 writeback ack, 6 writeback ack with data. Codes 0 and 3 form the own-exclusive event only when `req_id` equals SELF_ID and `req_kind` equals SELF_KIND; otherwise they form the foreign-exclusive event. The own-exclusive event pops the message, sends no data and leaves the state unchanged.
- R2: A shared read (code 1) is a separate event from a DMA read. In S, O, SM and OM it sends array data and keeps the state. In M and MM it sends array data and moves the line to O. In I, IS, IM, II and the reserved code it pops with no data.
- R3: Line state codes: I=0, S=1, O=2, M=3, MM=4, IS=5, IM=6, SM=7, OM=8, M_W=9, MM_W=10, MI=11, SI=12, OI=13, II=14, and 15 is reserved. A DMA read in S, O, SM, OM, M or MM sends non-exclusive data from the array, and the next state equals the current state. In I, IS, IM, II and 15 it pops with no data.
- R4: In MI, SI and OI, a shared read or a DMA read is answered with non-exclusive data from the writeback buffer, and the state is kept.
- R5: In M_W and MM_W, the own-exclusive, foreign-exclusive, shared-read, DMA-read and invalidate events are recycled. A recycle sends no data and leaves the state unchanged.
- R6: A foreign exclusive request sends exclusive data. In MI, SI and OI the data comes from the writeback buffer and the next state is II. In O, M and MM the data comes from the array and the next state is I. In OM the data comes from the array and the next state is IM. In every other state it pops with no data.
- R7: An invalidate moves S to I, SM to IM and SI to II, and sends no data. In every other state it pops with the state unchanged.
- R8: A writeback ack moves MI, SI, OI and II to I with no data. A writeback ack with data sends writeback-buffer data from MI, SI and OI and moves II to I. Both leave every other state unchanged.
- R9: When the outcome needs writeback-buffer data but `wbuf_valid` is low, the message is recycled with no data and the state is unchanged.
- R10: Outputs appear in the cycle after `req_valid` is sampled high. Exactly one of `pop` and `recycle` is asserted then. After a cycle with no request, `pop`, `recycle`, `rsp_valid` and `type_err` are all low.
- R11: A type code of 7 to 15 raises `type_err`, pops, sends no data and keeps the state.
- R12: While `rst_n` is low at a clock edge, all registered outputs are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request message is presented this cycle |
| req_type | input | 4 | Request type code |
| req_id | input | ID_W | Requestor identifier |
| req_kind | input | KIND_W | Requestor machine kind |
| req_addr | input | ADDR_W | Line address of the request |
| line_state | input | 4 | Current state of the addressed line |
| wbuf_valid | input | 1 | Writeback buffer holds data for this line |
| rsp_valid | output | 1 | Send a data response |
| rsp_from_wb | output | 1 | Response data comes from the writeback buffer (0: cache array) |
| rsp_excl | output | 1 | Response carries exclusive data |
| rsp_addr | output | ADDR_W | Address of the message that was handled |
| nxt_state | output | 4 | Next state to write back to the line |
| pop | output | 1 | Message consumed |
| recycle | output | 1 | Message to be retried later |
| type_err | output | 1 | Request type code not recognised |

## Verification
All state in the block sits in one output register stage, so a wrong entry in the decode or in the state table appears at the ports in the very next cycle. It shows up as a wrong next state, a wrong data source, a missing exclusive mark, or pop and recycle swapped. A DMA read that wrongly downgrades M, or that sends data from the array while the line is writeback-pending, can be seen in that same cycle. The sweep therefore covers every pair of type code and line state. For each pair it runs an own requestor, two kinds of foreign requestor (ID mismatch and kind mismatch), and both values of the writeback-valid flag.

// File: rtl/fwdq_pkg.sv
// Shared types for the forwarded-request handler.
// Assumes a 4-bit line state code and a 4-bit request type code.
package fwdq_pkg;

    typedef enum logic [3:0] {
        LS_I   = 4'd0,  LS_S   = 4'd1,  LS_O   = 4'd2,  LS_M   = 4'd3,
        LS_MM  = 4'd4,  LS_IS  = 4'd5,  LS_IM  = 4'd6,  LS_SM  = 4'd7,
        LS_OM  = 4'd8,  LS_MW  = 4'd9,  LS_MMW = 4'd10, LS_MI  = 4'd11,
        LS_SI  = 4'd12, LS_OI  = 4'd13, LS_II  = 4'd14, LS_RSV = 4'd15
    } line_st_t;

    localparam logic [3:0] RQ_EXCL  = 4'd0;
    localparam logic [3:0] RQ_SHRD  = 4'd1;
    localparam logic [3:0] RQ_DMARD = 4'd2;
    localparam logic [3:0] RQ_DMAWR = 4'd3;
    localparam logic [3:0] RQ_INV   = 4'd4;
    localparam logic [3:0] RQ_WBACK = 4'd5;
    localparam logic [3:0] RQ_WBDAT = 4'd6;

    typedef enum logic [2:0] {
        EV_OWN_X, EV_FWD_X, EV_FWD_S, EV_FWD_DMA,
        EV_INVAL, EV_WB_ACK, EV_WB_ACKD, EV_BAD
    } fwd_ev_t;

    typedef struct packed {
        logic     send;
        logic     from_wb;
        logic     excl;
        logic     pop;
        logic     recyc;
        logic     err;
        line_st_t nxt;
    } fwd_act_t;

endpackage

// File: rtl/fwdq_classify.sv
// Request classifier: turns a type code plus requestor identity into an event.
// Assumes SELF_ID / SELF_KIND identify this cache; purely combinational.
module fwdq_classify
    import fwdq_pkg::*;
#(
    parameter int ID_W      = 4,
    parameter int KIND_W    = 2,
    parameter int SELF_ID   = 3,
    parameter int SELF_KIND = 1
) (
    input  logic [3:0]        rq_type,
    input  logic [ID_W-1:0]   rq_id,
    input  logic [KIND_W-1:0] rq_kind,
    output fwd_ev_t           ev
);
    localparam logic [ID_W-1:0]   MY_ID   = ID_W'(SELF_ID);
    localparam logic [KIND_W-1:0] MY_KIND = KIND_W'(SELF_KIND);

    logic is_self;
    assign is_self = (rq_id == MY_ID) && (rq_kind == MY_KIND);

    // Map the type code to an event; exclusive kinds split by requestor identity.
    always_comb begin
        case (rq_type)
            RQ_EXCL, RQ_DMAWR: ev = is_self ? EV_OWN_X : EV_FWD_X;
            RQ_SHRD:           ev = EV_FWD_S;
            RQ_DMARD:          ev = EV_FWD_DMA;
            RQ_INV:            ev = EV_INVAL;
            RQ_WBACK:          ev = EV_WB_ACK;
            RQ_WBDAT:          ev = EV_WB_ACKD;
            default:           ev = EV_BAD;
        endcase
    end
endmodule

// File: rtl/fwdq_table.sv
// Transition table: applies an event to a line state and yields the action.
// Assumes a writeback-buffer source is only usable while wbuf_ok is high.
module fwdq_table
    import fwdq_pkg::*;
(
    input  fwd_ev_t  ev,
    input  line_st_t st,
    input  logic     wbuf_ok,
    output fwd_act_t act
);
    fwd_act_t base;
    logic     st_wait, st_wbk, st_has, st_own;

    assign st_wait = (st == LS_MW) || (st == LS_MMW);
    assign st_wbk  = (st inside {LS_MI, LS_SI, LS_OI});
    assign st_has  = (st inside {LS_S, LS_O, LS_SM, LS_OM, LS_M, LS_MM});
    assign st_own  = (st inside {LS_O, LS_M, LS_MM});

    // Base outcome per (state, event) before the buffer-availability check.
    always_comb begin
        base     = '0;
        base.pop = 1'b1;
        base.nxt = st;
        if (ev == EV_BAD) begin
            base.err = 1'b1;
        end else if (st_wait && (ev inside {EV_OWN_X, EV_FWD_X, EV_FWD_S,
                                             EV_FWD_DMA, EV_INVAL})) begin
            base.pop   = 1'b0;
            base.recyc = 1'b1;
        end else begin
            case (ev)
                EV_FWD_DMA, EV_FWD_S: begin
                    if (st_has) begin
                        base.send = 1'b1;
                        if (ev == EV_FWD_S && (st == LS_M || st == LS_MM))
                            base.nxt = LS_O;
                    end else if (st_wbk) begin
                        base.send    = 1'b1;
                        base.from_wb = 1'b1;
                    end
                end
                EV_FWD_X: begin
                    if (st_wbk) begin
                        base.send    = 1'b1;
                        base.from_wb = 1'b1;
                        base.excl    = 1'b1;
                        base.nxt     = LS_II;
                    end else if (st_own || st == LS_OM) begin
                        base.send = 1'b1;
                        base.excl = 1'b1;
                        base.nxt  = (st == LS_OM) ? LS_IM : LS_I;
                    end
                end
                EV_INVAL: begin
                    case (st)
                        LS_S:    base.nxt = LS_I;
                        LS_SM:   base.nxt = LS_IM;
                        LS_SI:   base.nxt = LS_II;
                        default: base.nxt = st;
                    endcase
                end
                EV_WB_ACK: begin
                    if (st_wbk || st == LS_II) base.nxt = LS_I;
                end
                EV_WB_ACKD: begin
                    if (st_wbk) begin
                        base.send    = 1'b1;
                        base.from_wb = 1'b1;
                    end
                    if (st_wbk || st == LS_II) base.nxt = LS_I;
                end
                default: base.nxt = st;
            endcase
        end
    end

    // Turn a buffer-sourced outcome into a retry when the buffer is not ready.
    always_comb begin
        act = base;
        if (base.send && base.from_wb && !wbuf_ok) begin
            act       = '0;
            act.recyc = 1'b1;
            act.nxt   = st;
        end
    end
endmodule

// File: rtl/fwd_handler.sv
// Forwarded-request handler top: classify, look up, then register the action.
// Assumes one message per cycle; outputs are valid the cycle after acceptance.
module fwd_handler
    import fwdq_pkg::*;
#(
    parameter int ID_W      = 4,
    parameter int KIND_W    = 2,
    parameter int ADDR_W    = 16,
    parameter int SELF_ID   = 3,
    parameter int SELF_KIND = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_type,
    input  logic [ID_W-1:0]   req_id,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        line_state,
    input  logic              wbuf_valid,
    output logic              rsp_valid,
    output logic              rsp_from_wb,
    output logic              rsp_excl,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [3:0]        nxt_state,
    output logic              pop,
    output logic              recycle,
    output logic              type_err
);
    fwd_ev_t  ev;
    fwd_act_t act;
    fwd_act_t act_q;

    fwdq_classify #(
        .ID_W(ID_W), .KIND_W(KIND_W), .SELF_ID(SELF_ID), .SELF_KIND(SELF_KIND)
    ) u_cls (
        .rq_type(req_type), .rq_id(req_id), .rq_kind(req_kind), .ev(ev)
    );

    fwdq_table u_tbl (
        .ev(ev), .st(line_st_t'(line_state)), .wbuf_ok(wbuf_valid), .act(act)
    );

    // Capture the action of an accepted message; idle cycles clear it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= '0;
            rsp_addr <= '0;
        end else begin
            act_q    <= req_valid ? act : '0;
            rsp_addr <= req_valid ? req_addr : rsp_addr;
        end
    end

    assign rsp_valid   = act_q.send;
    assign rsp_from_wb = act_q.from_wb;
    assign rsp_excl    = act_q.excl;
    assign nxt_state   = act_q.nxt;
    assign pop         = act_q.pop;
    assign recycle     = act_q.recyc;
    assign type_err    = act_q.err;
endmodule

// File: rtl/fwd_handler_check.sv
// Property checker for fwd_handler; keeps its own copy of the accepted inputs.
module fwd_handler_check (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [3:0] req_type,
    input logic [3:0] line_state,
    input logic       wbuf_valid,
    input logic       rsp_valid,
    input logic       rsp_from_wb,
    input logic       rsp_excl,
    input logic [3:0] nxt_state,
    input logic       pop,
    input logic       recycle,
    input logic       type_err
);
    logic       seen;
    logic [3:0] q_state;
    logic [3:0] q_type;
    logic       q_wbuf;

    // Remember what was presented in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen    <= 1'b0;
            q_state <= '0;
            q_type  <= '0;
            q_wbuf  <= 1'b0;
        end else begin
            seen    <= req_valid;
            q_state <= line_state;
            q_type  <= req_type;
            q_wbuf  <= wbuf_valid;
        end
    end

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (pop ^ recycle));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> !(pop || recycle || rsp_valid || type_err));
    p_recycle_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        recycle |-> (!rsp_valid && nxt_state == q_state));
    p_wb_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_from_wb) |-> q_wbuf);
    p_bad_type_r11: assert property (@(posedge clk) disable iff (!rst_n)
        type_err |-> (pop && !rsp_valid && nxt_state == q_state && q_type > 4'd6));
    p_dma_no_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && q_type == 4'd2) |-> (nxt_state == q_state && !rsp_excl));
    p_excl_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_excl |-> rsp_valid);
endmodule

bind fwd_handler fwd_handler_check u_fwd_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .line_state(line_state), .wbuf_valid(wbuf_valid), .rsp_valid(rsp_valid),
    .rsp_from_wb(rsp_from_wb), .rsp_excl(rsp_excl), .nxt_state(nxt_state),
    .pop(pop), .recycle(recycle), .type_err(type_err)
);

// File: tb/fwd_handler_bench.sv
// Exhaustive sweep: every type code x line state x requestor identity x buffer flag.
module fwd_handler_bench;
    localparam int ID_W = 4, KIND_W = 2, ADDR_W = 16, SID = 3, SKIND = 1;

    logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, wbuf_valid = 1'b0;
    logic [3:0] req_type = '0, line_state = '0;
    logic [ID_W-1:0] req_id = '0;
    logic [KIND_W-1:0] req_kind = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic rsp_valid, rsp_from_wb, rsp_excl, pop, recycle, type_err;
    logic [ADDR_W-1:0] rsp_addr;
    logic [3:0] nxt_state;
    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fwd_handler #(.ID_W(ID_W), .KIND_W(KIND_W), .ADDR_W(ADDR_W),
                  .SELF_ID(SID), .SELF_KIND(SKIND)) u_fwd_handler (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_id(req_id), .req_kind(req_kind), .req_addr(req_addr),
        .line_state(line_state), .wbuf_valid(wbuf_valid), .rsp_valid(rsp_valid),
        .rsp_from_wb(rsp_from_wb), .rsp_excl(rsp_excl), .rsp_addr(rsp_addr),
        .nxt_state(nxt_state), .pop(pop), .recycle(recycle), .type_err(type_err));

    // Expected {send, from_wb, excl, pop, recycle, err, nxt[3:0]} from the requirements.
    function automatic logic [9:0] model(int st, int ty, bit self_rq, bit wb);
        bit s = 0, w = 0, x = 0, rc = 0, er = 0;
        int n = st;
        bit wbk  = (st == 11 || st == 12 || st == 13);
        bit hold = (st >= 1 && st <= 4) || st == 7 || st == 8;
        if (ty > 6) er = 1;
        else if ((st == 9 || st == 10) && ty <= 4) rc = 1;
        else if (ty == 1 || ty == 2) begin
            if (hold) begin s = 1; if (ty == 1 && (st == 3 || st == 4)) n = 2; end
            else if (wbk) begin s = 1; w = 1; end
        end else if ((ty == 0 || ty == 3) && !self_rq) begin
            if (wbk) begin s = 1; w = 1; x = 1; n = 14; end
            else if (st == 2 || st == 3 || st == 4) begin s = 1; x = 1; n = 0; end
            else if (st == 8) begin s = 1; x = 1; n = 6; end
        end else if (ty == 4) begin
            if (st == 1) n = 0; else if (st == 7) n = 6; else if (st == 12) n = 14;
        end else if (ty == 5 || ty == 6) begin
            if (wbk || st == 14) n = 0;
            if (ty == 6 && wbk) begin s = 1; w = 1; end
        end
        if (s && w && !wb) begin s = 0; w = 0; x = 0; rc = 1; n = st; end
        return {s, w, x, !rc, rc, er, 4'(n)};
    endfunction

    function automatic string tag(int st, int ty, bit self_rq, bit wb);
        bit wbk = (st == 11 || st == 12 || st == 13);
        if (ty > 6) return "R11";
        if ((st == 9 || st == 10) && ty <= 4) return "R5";
        if (!wb && wbk && (ty == 1 || ty == 2 || ty == 6 || ((ty == 0 || ty == 3) && !self_rq)))
            return "R9";
        if (ty == 2) return wbk ? "R4" : "R3";
        if (ty == 1) return wbk ? "R4" : "R2";
        if (ty == 0 || ty == 3) return self_rq ? "R1" : "R6";
        if (ty == 4) return "R7";
        return "R8";
    endfunction

    task automatic check(string rq, logic [9:0] got, logic [9:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", rq, got, exp);
        end
    endtask

    function automatic logic [9:0] outs();
        return {rsp_valid, rsp_from_wb, rsp_excl, pop, recycle, type_err, nxt_state};
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        req_valid = 1'b1; req_type = 4'd1; line_state = 4'd3;
        repeat (3) @(negedge clk);
        check("R12", outs(), 10'b0);                 // reset clears outputs
        rst_n = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        check("R10", outs(), 10'b0);                 // idle cycle is quiet
        for (int st = 0; st < 16; st++)
            for (int ty = 0; ty < 16; ty++)
                for (int who = 0; who < 3; who++)
                    for (int wb = 0; wb < 2; wb++) begin
                        req_valid  = 1'b1;
                        line_state = 4'(st);
                        req_type   = 4'(ty);
                        req_id     = (who == 1) ? ID_W'(SID + 1) : ID_W'(SID);
                        req_kind   = (who == 2) ? KIND_W'(SKIND + 1) : KIND_W'(SKIND);
                        wbuf_valid = wb[0];
                        req_addr   = ADDR_W'(st * 512 + ty * 8 + who * 2 + wb);
                        @(negedge clk);
                        check(tag(st, ty, who == 0, wb[0]), outs(),
                              model(st, ty, who == 0, wb[0]));
                        check("R10", {6'b0, rsp_addr[3:0]},
                              {6'b0, 4'(ty * 8 + who * 2 + wb)});
                    end
        req_valid = 1'b0;
        @(negedge clk);
        check("R10", outs(), 10'b0);
        req_valid = 1'b1; req_type = 4'd2; line_state = 4'd3; rst_n = 1'b0;
        @(negedge clk);
        check("R12", outs(), 10'b0);                 // reset mid-stream
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule